// File: doc/BRIEF.md
# Configuration Cell Responder

This block answers requests on a dynamic reconfiguration style port. It holds a small bank of configuration cells, `CELLS` cells of `DATA_W` bits each. It serves one request at a time: a read or a write, started by an enable pulse. After a fixed, parameterised latency it raises a one-cycle ready strobe. Its main use is as a target that exercises and checks master logic elsewhere in the same design. Masters that sample read data too early see a fixed poison word rather than plausible data.

A request is taken on a rising clock edge where the enable input is high. At that edge the block samples the operation, the address and the write data, and it ignores those inputs for the rest of the request. While a request is pending, any further enable is dropped and a sticky collision flag is set. Reset loads each cell with a parameterised default. That default is either one common word or the common word XORed with the cell index.

Top module: `cfg_port_target`

## Requirements
- R1: While reset is asserted and after it is released, every cell holds its default: `INIT_VAL` when `INIT_MODE` is 0, and `INIT_VAL ^ index` when `INIT_MODE` is 1. `rsp_ready` and `collision` are low.
- R2: An edge where `req_en` is high and no request is pending starts a request. `req_wr` = 0 selects a read and 1 selects a write. `req_wr`, `req_addr` and `req_wdata` are sampled only at that edge, and later changes have no effect on the request.
- R3: `rsp_ready` is high for exactly one cycle, `LATENCY` cycles after the enable cycle. With `LATENCY` = 1 it is high in the cycle right after the enable cycle.
- R4: In the ready cycle of a read, `rsp_rdata` carries the content of the addressed cell.
- R5: A write has updated its cell by the time ready is returned. A later read of that cell returns the new word, and all other cells keep their values.
- R6: `rsp_rdata` equals `POISON` whenever `rsp_ready` is low, and also in the ready cycle of a write.
- R7: An enable sampled while a request is pending has no effect. A request counts as pending from its enable edge up to and including the edge that ends its ready cycle. A dropped enable produces no extra ready and changes no cell.
- R8: `collision` goes high after the edge that samples a dropped enable, and it stays high until reset.
- R9: An enable driven in the cycle after a ready cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all port timing refers to its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_en | input | 1 | Request enable, one cycle per request |
| req_wr | input | 1 | 0 = read, 1 = write; sampled with `req_en` |
| req_addr | input | $clog2(CELLS) | Cell index, sampled with `req_en` |
| req_wdata | input | DATA_W | Write word, sampled with `req_en` |
| rsp_rdata | output | DATA_W | Read word in the ready cycle of a read, `POISON` otherwise |
| rsp_ready | output | 1 | One-cycle completion strobe |
| collision | output | 1 | Sticky flag: an enable was dropped while busy |

## Verification
A request enabled before edge k has its ready strobe after edge k+LATENCY-1. The bench samples every output at the falling edge in the middle of each cycle. For samples 1 to LATENCY-1 after the enable edge it expects ready low and the poison word. At sample LATENCY it expects ready and the read word, and at the next sample it expects ready low again. The collision flag is checked one full sample after the edge that sees the dropped enable. Address and write data are scrambled in the first cycle after capture, which shows that only the sampled values count. A sweep reads every cell, writes every cell and reads it back, with the expected words computed arithmetically from the index.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } op_e;

   localparam int INIT_UNIFORM = 0;
   localparam int INIT_INDEXED = 1;
endpackage

// File: rtl/cfg_cell_array.sv
module cfg_cell_array
   import cfg_port_pkg::*;
#(
   parameter int DATA_W                 = 16,
   parameter int CELLS                  = 8,
   parameter int INIT_MODE              = INIT_UNIFORM,
   parameter logic [DATA_W-1:0] INIT_VAL = '0,
   localparam int ADDR_W                = $clog2(CELLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [CELLS-1:0][DATA_W-1:0] cell_bus;

   for (genvar i = 0; i < CELLS; i++) begin : g_cell
      localparam logic [DATA_W-1:0] SEED =
         (INIT_MODE == INIT_INDEXED) ? (INIT_VAL ^ DATA_W'(i)) : INIT_VAL;
      logic [DATA_W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= SEED;
         else if (wr_en && (wr_addr == ADDR_W'(i)))
            q <= wr_data;
      end

      assign cell_bus[i] = q;
   end

   assign rd_data = cell_bus[rd_addr];
endmodule

// File: rtl/cfg_req_tracker.sv
module cfg_req_tracker #(
   parameter int LATENCY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_en,
   output logic accept,
   output logic ready,
   output logic collision
);
   logic busy;

   assign accept = req_en && !busy;

   if (LATENCY == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ready <= 1'b0;
         else        ready <= accept;
      end
      assign busy = ready;
   end else begin : g_count
      localparam int CNT_W = $clog2(LATENCY + 1);
      logic [CNT_W-1:0] cnt;
      logic             busy_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
            ready  <= 1'b0;
            cnt    <= '0;
         end else if (accept) begin
            busy_q <= 1'b1;
            cnt    <= CNT_W'(LATENCY - 1);
         end else if (busy_q) begin
            if (ready) begin
               busy_q <= 1'b0;
               ready  <= 1'b0;
            end else begin
               cnt <= cnt - 1'b1;
               if (cnt == CNT_W'(1)) ready <= 1'b1;
            end
         end
      end
      assign busy = busy_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         collision <= 1'b0;
      else if (req_en && busy)
         collision <= 1'b1;
   end
endmodule

// File: rtl/cfg_port_target.sv
module cfg_port_target
   import cfg_port_pkg::*;
#(
   parameter int DATA_W                  = 16,
   parameter int CELLS                   = 8,
   parameter int LATENCY                 = 3,
   parameter int INIT_MODE               = INIT_UNIFORM,
   parameter logic [DATA_W-1:0] INIT_VAL = '0,
   parameter logic [DATA_W-1:0] POISON   = {(DATA_W/4){4'hD}},
   localparam int ADDR_W                 = $clog2(CELLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_en,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_ready,
   output logic              collision
);
   if (CELLS < 2 || (1 << ADDR_W) != CELLS) begin : g_bad_cells
      $error("CELLS must be a power of two of at least 2");
   end
   if (LATENCY < 1) begin : g_bad_latency
      $error("LATENCY must be at least 1");
   end
   if (INIT_MODE != INIT_UNIFORM && INIT_MODE != INIT_INDEXED) begin : g_bad_init
      $error("INIT_MODE must be 0 or 1");
   end
   if (DATA_W < 4) begin : g_bad_width
      $error("DATA_W must be at least 4");
   end

   logic              accept;
   logic              ready;
   op_e               op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] cell_word;

   cfg_req_tracker #(.LATENCY(LATENCY)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_en    (req_en),
      .accept    (accept),
      .ready     (ready),
      .collision (collision)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_READ;
         addr_q <= '0;
      end else if (accept) begin
         op_q   <= req_wr ? OP_WRITE : OP_READ;
         addr_q <= req_addr;
      end
   end

   cfg_cell_array #(
      .DATA_W    (DATA_W),
      .CELLS     (CELLS),
      .INIT_MODE (INIT_MODE),
      .INIT_VAL  (INIT_VAL)
   ) u_cells (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (accept && req_wr),
      .wr_addr (req_addr),
      .wr_data (req_wdata),
      .rd_addr (addr_q),
      .rd_data (cell_word)
   );

   assign rsp_ready = ready;
   assign rsp_rdata = (ready && op_q == OP_READ) ? cell_word : POISON;
endmodule

// File: rtl/cfg_port_target_chk.sv
module cfg_port_target_chk #(
   parameter int DATA_W                = 16,
   parameter int LATENCY               = 3,
   parameter logic [DATA_W-1:0] POISON = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_en,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_ready,
   input logic              collision
);
   localparam int CW = $clog2(LATENCY + 1) + 1;
   logic          c_busy;
   logic [CW-1:0] c_cnt;
   logic          c_due;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_busy <= 1'b0;
         c_cnt  <= '0;
      end else if (!c_busy) begin
         if (req_en) begin
            c_busy <= 1'b1;
            c_cnt  <= CW'(1);
         end
      end else if (c_cnt == CW'(LATENCY)) begin
         c_busy <= 1'b0;
      end else begin
         c_cnt <= c_cnt + 1'b1;
      end
   end

   assign c_due = c_busy && (c_cnt == CW'(LATENCY));

   a_r3_ready_only_when_due: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |-> c_due);
   a_r3_due_brings_ready: assert property (@(posedge clk) disable iff (!rst_n)
      c_due |-> rsp_ready);
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |=> !rsp_ready);
   a_r6_poison_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_ready |-> (rsp_rdata == POISON));
   a_r7_busy_enable_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (req_en && c_busy) |=> collision);
   a_r8_collision_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      collision |=> collision);
endmodule

bind cfg_port_target cfg_port_target_chk #(
   .DATA_W  (DATA_W),
   .LATENCY (LATENCY),
   .POISON  (POISON)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_en    (req_en),
   .rsp_rdata (rsp_rdata),
   .rsp_ready (rsp_ready),
   .collision (collision)
);

// File: tb/sim_cfg_port_target.sv
`timescale 1ns/1ps
module sim_cfg_port_target;
   localparam int                DW   = 16;
   localparam int                NC   = 8;
   localparam int                AW   = 3;
   localparam int                LAT  = 3;
   localparam logic [DW-1:0]     IVAL = 16'hA5C0;
   localparam logic [DW-1:0]     PSN  = 16'hDEAD;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_en = 1'b0;
   logic          req_wr = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_ready;
   logic          collision;

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] model [NC];

   always #5 clk = ~clk;

   cfg_port_target #(
      .DATA_W(DW), .CELLS(NC), .LATENCY(LAT),
      .INIT_MODE(1), .INIT_VAL(IVAL), .POISON(PSN)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata), .rsp_ready(rsp_ready), .collision(collision)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the falling edge after the ready cycle.
   task automatic access(input bit wr, input int addr, input logic [DW-1:0] data, input bit inject);
      req_en = 1'b1; req_wr = wr; req_addr = AW'(addr); req_wdata = data;
      @(posedge clk);
      for (int i = 1; i <= LAT; i++) begin
         @(negedge clk);
         if (i == 1) begin
            // R2: scramble after capture; R7: optional enable while pending
            req_en = inject; req_wr = 1'b1;
            req_addr = ~AW'(addr); req_wdata = ~data;
         end else begin
            req_en = 1'b0;
         end
         if (i < LAT) begin
            check("R3 early ready", 32'(rsp_ready), 32'd0);
            check("R6 early data", 32'(rsp_rdata), 32'(PSN));
         end else begin
            check("R3 ready due", 32'(rsp_ready), 32'd1);
            if (wr) check("R6 write data", 32'(rsp_rdata), 32'(PSN));
            else    check("R4 R5 read data", 32'(rsp_rdata), 32'(model[addr]));
         end
      end
      if (wr) model[addr] = data;
      @(negedge clk);
      req_en = 1'b0;
      check("R3 R7 single pulse", 32'(rsp_ready), 32'd0);
      check("R6 idle data", 32'(rsp_rdata), 32'(PSN));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < NC; i++) model[i] = IVAL ^ DW'(i);
      repeat (3) @(negedge clk);
      check("R1 ready in reset", 32'(rsp_ready), 32'd0);
      check("R1 collision in reset", 32'(collision), 32'd0);
      check("R6 data in reset", 32'(rsp_rdata), 32'(PSN));
      rst_n = 1'b1;
      @(negedge clk);
      // R1 R4 R9: back-to-back reads of defaults
      for (int i = 0; i < NC; i++) access(1'b0, i, '0, 1'b0);
      check("R8 no collision yet", 32'(collision), 32'd0);
      // R5: write sweep then readback
      for (int i = 0; i < NC; i++) access(1'b1, i, DW'(i * 16'h1111) ^ 16'h0F0F, 1'b0);
      for (int i = 0; i < NC; i++) access(1'b0, i, '0, 1'b0);
      // R7 R8: enable while pending is dropped
      access(1'b1, 2, 16'h1234, 1'b1);
      check("R8 collision set", 32'(collision), 32'd1);
      access(1'b0, 5, '0, 1'b0);
      access(1'b0, 2, '0, 1'b0);
      access(1'b0, 6, '0, 1'b1);
      access(1'b0, 1, '0, 1'b0);
      check("R8 collision sticky", 32'(collision), 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule